// File: doc/BRIEF.md
# External Interrupt Source Conditioner

This block turns raw event sources into the pending flags of two external interrupt requests. The first request comes from an active-low pin. A select input picks either a primary or an alternate pin. The chosen pin is brought into the system clock domain through a flip-flop synchroniser. A trigger-mode input then decides how the flag behaves. In edge mode, a falling edge latches the flag. In level mode, the flag tracks the inverted pin level.

The second request has no pin behind it. When its gate input is high, it fires once for every second one-cycle tick from the low-frequency oscillator. When the gate input is low, it fires on a strobe that signals the oscillator has resumed from suspend. Both flags are set by reset. Software clears a flag with a one-cycle strobe, and it is expected to do this before enabling the interrupt. Priority and vectoring belong to the interrupt controller that reads these flags.

Top module: `eirq_cond`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `flag0` and `flag1` both read 1.
- R2: In edge mode (`edge_mode`=1), a falling edge on the selected pin sets `flag0` on the third rising clock edge after the pin changes. The flag then stays set whatever the pin does, including a return to high, until `clr0` is sampled. A rising edge never sets the flag.
- R3: In edge mode, `clr0` sampled high clears `flag0` on that clock edge. If a detected falling edge is sampled in the same cycle, the set wins.
- R4: In level mode (`edge_mode`=0), each clock edge loads `flag0` with the inverted synchronised pin level, three clock edges after the pin changes. `clr0` has no effect in this mode.
- R5: With `alt_sel`=0 the source is `pin_pri`. With `alt_sel`=1 it is `pin_alt`, and activity on `pin_pri` is ignored.
- R6: While `in_enable` is 0, no falling edge is detected, so `flag0` does not become set in edge mode.
- R7: With `gate_sel`=1, `flag1` is set on the clock edge of every second `slow_tick` pulse. The tick counter starts at zero after reset.
- R8: With `gate_sel`=1, `osc_resume` has no effect on `flag1`.
- R9: With `gate_sel`=0, `osc_resume` sets `flag1` on the clock edge where it is sampled. In this mode `slow_tick` is ignored and the tick counter is held at zero.
- R10: `clr1` sampled high clears `flag1`. If a set event is sampled in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_enable | input | 1 | Global input enable; when 0, falling-edge detection is suppressed |
| pin_pri | input | 1 | Primary active-low pin for request 0 |
| pin_alt | input | 1 | Alternate active-low pin for request 0 |
| alt_sel | input | 1 | 1 selects `pin_alt` |
| edge_mode | input | 1 | 1 = falling-edge trigger, 0 = low-level trigger |
| gate_sel | input | 1 | 1 = periodic tick source, 0 = oscillator-resume source |
| slow_tick | input | 1 | One-cycle enable marking a low-frequency oscillator cycle |
| osc_resume | input | 1 | One-cycle strobe marking oscillator resume |
| clr0 | input | 1 | Clear strobe for `flag0` |
| clr1 | input | 1 | Clear strobe for `flag1` |
| flag0 | output | 1 | Pending flag of request 0 |
| flag1 | output | 1 | Pending flag of request 1 |

## Verification
The pin request is driven with single falling edges, rising edges, long low levels, and with a clear strobe placed in the same cycle as a detected edge. Together these separate edge latching from level following, and they also show that a set beats a clear. The same falling edge is repeated on the unselected pin and with the input enable low, to show that it is ignored. The tick request gets one tick and then a second one, so that divide-by-two firing can be told apart from firing on every tick. It also gets three ticks while gated off, followed by one tick with the gate back on, which shows that the counter is held at zero. Resume strobes are applied in both gate settings.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int SYNC_STAGES_DEF = 2;
    localparam int TICK_DIV_DEF    = 2;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    typedef enum logic {
        SRC_RESUME = 1'b0,
        SRC_TICK   = 1'b1
    } tick_src_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       in_en;
    } pin_cfg_t;

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/eirq_pin_src.sv
module eirq_pin_src
    import eirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  pin_cfg_t cfg,
    input  logic     clr,
    output logic     flag
);
    logic prev_q;
    logic flag_q;
    logic fall;

    assign fall = cfg.in_en & prev_q & ~lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_q <= 1'b1;
        end else begin
            prev_q <= lvl;
            if (cfg.mode == TRIG_EDGE) flag_q <= sticky_next(flag_q, fall, clr);
            else                       flag_q <= ~lvl;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/eirq_tick_src.sv
module eirq_tick_src
    import eirq_pkg::*;
#(
    parameter int TICK_DIV = TICK_DIV_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_src_e src,
    input  logic      slow_tick,
    input  logic      osc_resume,
    input  logic      clr,
    output logic      flag
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          flag_q;
    logic          wrap;
    logic          set;

    assign wrap = (src == SRC_TICK) & slow_tick & (cnt_q == LAST);
    assign set  = (src == SRC_TICK) ? wrap : osc_resume;

    always_ff @(posedge clk) begin
        if (rst || src != SRC_TICK) cnt_q <= '0;
        else if (slow_tick)         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b1;
        else     flag_q <= sticky_next(flag_q, set, clr);
    end

    assign flag = flag_q;
endmodule

// File: rtl/eirq_cond.sv
module eirq_cond
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int TICK_DIV    = TICK_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic in_enable,
    input  logic pin_pri,
    input  logic pin_alt,
    input  logic alt_sel,
    input  logic edge_mode,
    input  logic gate_sel,
    input  logic slow_tick,
    input  logic osc_resume,
    input  logic clr0,
    input  logic clr1,
    output logic flag0,
    output logic flag1
);
    logic     sel_raw;
    logic     sel_sync;
    pin_cfg_t pcfg;

    assign sel_raw    = alt_sel ? pin_alt : pin_pri;
    assign pcfg.mode  = trig_mode_e'(edge_mode);
    assign pcfg.in_en = in_enable;

    eirq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(sel_raw), .q(sel_sync)
    );

    eirq_pin_src u_pin (
        .clk(clk), .rst(rst), .lvl(sel_sync), .cfg(pcfg), .clr(clr0), .flag(flag0)
    );

    eirq_tick_src #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .src(tick_src_e'(gate_sel)), .slow_tick(slow_tick),
        .osc_resume(osc_resume), .clr(clr1), .flag(flag1)
    );
endmodule

// File: rtl/eirq_cond_chk.sv
module eirq_cond_chk (
    input logic clk,
    input logic rst,
    input logic in_enable,
    input logic edge_mode,
    input logic gate_sel,
    input logic slow_tick,
    input logic osc_resume,
    input logic clr0,
    input logic clr1,
    input logic flag0,
    input logic flag1,
    input logic sel_sync
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_FLAGS: assert (flag0 && flag1) else $error("reset flags"); // R1
        end
    end

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        edge_mode && flag0 && !clr0 |=> flag0); // R2
    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        edge_mode && clr0 && !in_enable |=> !flag0); // R3
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !edge_mode |=> flag0 == !$past(sel_sync)); // R4
    AST_EDGE_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        edge_mode && !in_enable && !flag0 |=> !flag0); // R6
    AST_TICK_NO_RESUME: assert property (@(posedge clk) disable iff (rst)
        gate_sel && !slow_tick && !clr1 |=> $stable(flag1)); // R8
    AST_RESUME_ONLY: assert property (@(posedge clk) disable iff (rst)
        !gate_sel && !osc_resume && !flag1 |=> !flag1); // R9
    AST_CLR1_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr1 && !slow_tick && !osc_resume |=> !flag1); // R10
endmodule

bind eirq_cond eirq_cond_chk u_chk (
    .clk(clk), .rst(rst), .in_enable(in_enable), .edge_mode(edge_mode),
    .gate_sel(gate_sel), .slow_tick(slow_tick), .osc_resume(osc_resume),
    .clr0(clr0), .clr1(clr1), .flag0(flag0), .flag1(flag1), .sel_sync(sel_sync)
);

// File: tb/eirq_cond_tb_top.sv
module eirq_cond_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst, in_enable, pin_pri, pin_alt, alt_sel, edge_mode, gate_sel;
    logic slow_tick, osc_resume, clr0, clr1;
    logic flag0, flag1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        string req;
        bit    use0;
        bit    e0;
        bit    use1;
        bit    e1;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eirq_cond dut_i (
        .clk(clk), .rst(rst), .in_enable(in_enable), .pin_pri(pin_pri), .pin_alt(pin_alt),
        .alt_sel(alt_sel), .edge_mode(edge_mode), .gate_sel(gate_sel), .slow_tick(slow_tick),
        .osc_resume(osc_resume), .clr0(clr0), .clr1(clr1), .flag0(flag0), .flag1(flag1)
    );

    // monitor: compares queued expectations against outputs just after each falling edge
    always begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if ((it.use0 && flag0 !== it.e0) || (it.use1 && flag1 !== it.e1)) begin
                errors++;
                $display("FAIL %s: flag0=%b flag1=%b expected flag0=%s flag1=%s", it.req,
                         flag0, flag1, it.use0 ? (it.e0 ? "1" : "0") : "-",
                         it.use1 ? (it.e1 ? "1" : "0") : "-");
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp0(input string req, input bit v);
        sb_q.push_back('{req, 1'b1, v, 1'b0, 1'b0});
    endtask

    task automatic exp1(input string req, input bit v);
        sb_q.push_back('{req, 1'b0, 1'b0, 1'b1, v});
    endtask

    task automatic pulse_clr0;
        clr0 = 1; step(1); clr0 = 0;
    endtask

    task automatic pulse_clr1;
        clr1 = 1; step(1); clr1 = 0;
    endtask

    task automatic tick;
        slow_tick = 1; step(1); slow_tick = 0;
    endtask

    task automatic resume;
        osc_resume = 1; step(1); osc_resume = 0;
    endtask

    task automatic finish_run;
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; in_enable = 1; pin_pri = 1; pin_alt = 1; alt_sel = 0; edge_mode = 1;
        gate_sel = 0; slow_tick = 0; osc_resume = 0; clr0 = 0; clr1 = 0;
        step(3);
        exp0("R1", 1); exp1("R1", 1);
        rst = 0; step(1);
        exp0("R1", 1); exp1("R1", 1);
        clr0 = 1; clr1 = 1; step(1); clr0 = 0; clr1 = 0;
        exp0("R3", 0); exp1("R10", 0);

        // R2: falling edge latency and hold
        pin_pri = 0; step(2); exp0("R2", 0);
        step(1); exp0("R2", 1);
        step(5); exp0("R2", 1);
        pin_pri = 1; step(4); exp0("R2", 1);
        pulse_clr0; exp0("R3", 0);
        step(3); exp0("R2", 0);

        // R3: set beats clear in the same cycle
        pin_pri = 0; step(2);
        pulse_clr0; exp0("R3", 1);
        pulse_clr0; exp0("R3", 0);
        pin_pri = 1; step(3);

        // R6: input enable low suppresses edge detection
        in_enable = 0; pin_pri = 0; step(4); exp0("R6", 0);
        pin_pri = 1; step(3); in_enable = 1; step(1); exp0("R6", 0);

        // R5: alternate pin selection
        alt_sel = 1; step(3);
        pin_pri = 0; step(4); exp0("R5", 0);
        pin_pri = 1; pin_alt = 0; step(3); exp0("R5", 1);
        pulse_clr0; exp0("R5", 0);
        pin_alt = 1; step(3); alt_sel = 0; step(3); exp0("R5", 0);

        // R4: level mode follows the pin; clear ignored
        edge_mode = 0; step(1); exp0("R4", 0);
        pin_pri = 0; step(2); exp0("R4", 0);
        step(1); exp0("R4", 1);
        pulse_clr0; exp0("R4", 1);
        pin_pri = 1; step(3); exp0("R4", 0);
        edge_mode = 1; step(1); exp0("R2", 0);

        // R7: divide-by-two periodic source
        gate_sel = 1; step(1);
        tick; exp1("R7", 0);
        tick; exp1("R7", 1);
        pulse_clr1; exp1("R10", 0);
        tick; exp1("R7", 0);
        tick; exp1("R7", 1);
        pulse_clr1; exp1("R10", 0);

        // R8: resume ignored while gated to ticks
        resume; exp1("R8", 0);

        // R9: resume source, ticks ignored and counter held
        gate_sel = 0; step(1);
        tick; exp1("R9", 0);
        tick; exp1("R9", 0);
        tick; exp1("R9", 0);
        resume; exp1("R9", 1);
        pulse_clr1; exp1("R10", 0);

        // R10: set beats clear
        osc_resume = 1; clr1 = 1; step(1); osc_resume = 0; clr1 = 0;
        exp1("R10", 1);
        pulse_clr1; exp1("R10", 0);

        // counter held at zero while gated off: needs two fresh ticks
        gate_sel = 1; step(1);
        tick; exp1("R9", 0);
        tick; exp1("R7", 1);

        done = 1;
        finish_run;
    end
endmodule